// File: doc/BRIEF.md
# Filtered Performance Event Counter

This block is a single programmable hardware event counter intended to sit beside a processor pipeline. Software programs a 64-bit event-select word that names the event to watch (a 12-bit code plus an 8-bit unit mask), the privilege levels to count in, a host/guest virtualization filter, an optional occurrence threshold with invert and edge qualifiers, a counter enable and an interrupt enable. Every clock, the pipeline presents a report on the event bus: a code, a unit-mask vector and the number of occurrences seen in that cycle.

The block decides each cycle whether the report qualifies, turns it into an increment, and adds that increment to a 48-bit count that software can preload and read. Software normally preloads a negative period, with bit 47 set. The wrap past the top of the count, seen as bit 47 falling from 1 to 0, sets a sticky interrupt flag, which software clears by pulsing a clear input.

The event bus is a valid-qualified stream with no back-pressure: the counter takes a report in every cycle where `evt_valid` is high, and there is no ready signal. The control inputs (select write, count write, mode pins, interrupt clear) are plain level or pulse inputs sampled on the rising clock edge.

Top module: `pmc_event_counter`

## Requirements
- R1: After reset the count is 0, the select word is 0 and `irq` is low. With select 0 nothing is counted.
- R2: A report matches when `evt_valid` is 1 and `evt_code` equals the 12-bit select code. The code's low byte is select bits 7:0 and its high nibble is select bits 35:32. With the threshold field at 0, a qualified match adds `evt_occ` to the count on the next edge. A select write takes effect from the following cycle.
- R3: A match also needs the bitwise AND of `evt_umask` and the select unit mask (bits 15:8) to be nonzero. A select unit mask of 0 matches nothing.
- R4: Counting needs the enable bit (22) and the privilege bit for the current mode: bit 16 when `priv_user` is 1, bit 17 when it is 0. With bits 16 and 17 both 0 the count never changes.
- R5: With host-only (bit 41) set alone, counting happens only while `guest_mode` is 0. With guest-only (bit 40) set alone, counting happens only while `guest_mode` is 1.
- R6: With host-only and guest-only both set, counting happens in both host and guest mode, exactly as when neither is set.
- R7: While `virt_mask` is 1, the host-only bit is treated as 0. A host-only event then counts in every mode, and a guest-only event counts nothing while `guest_mode` is 0.
- R8: With a nonzero threshold (bits 31:24) and edge (bit 18) at 0, the count rises by exactly 1 in each qualified cycle whose matched occurrence count is at least the threshold. When invert (bit 23) is set, the condition is "below the threshold" instead, and a cycle with no match has 0 occurrences.
- R9: With a nonzero threshold and edge at 1, the count rises by 1 only in a qualified cycle where the R8 condition is true and was false in the previous cycle. The condition is tracked in every cycle and reads as false while the threshold is 0.
- R10: A count write loads the low 48 bits of `cnt_wr_data` on the next edge and overrides any increment in that cycle.
- R11: An increment that carries bit 47 of the count from 1 to 0 sets `irq` on the same edge when interrupt-enable (bit 20) is set. A count write never sets `irq`.
- R12: `irq` stays high until a cycle with `irq_clr` at 1, after which it is low. If a wrap and a clear fall in the same cycle, the wrap wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr_en | input | 1 | Load the select word |
| sel_wr_data | input | 64 | New select word |
| cnt_wr_en | input | 1 | Load the count |
| cnt_wr_data | input | 64 | New count; only the low 48 bits are kept |
| cnt_value | output | 48 | Current count |
| evt_valid | input | 1 | Event report present this cycle |
| evt_code | input | 12 | Event code of the report |
| evt_umask | input | 8 | Unit-mask vector of the report |
| evt_occ | input | 4 | Occurrences in this cycle |
| priv_user | input | 1 | 1 in user mode, 0 in OS mode |
| guest_mode | input | 1 | 1 while a guest runs, 0 in host mode |
| virt_mask | input | 1 | Treat the host-only bit as clear |
| irq | output | 1 | Sticky overflow interrupt |
| irq_clr | input | 1 | Clear the interrupt |

## Verification
The bench builds the counter with its default parameters: a 48-bit count and a 4-bit occurrence field. With that width, a single report can add up to 15. Preloading a count one or two below 2^48 therefore makes the wrap, the interrupt, and its race with a clear reachable within a few cycles. The 4-bit occurrence field, next to the 8-bit threshold, lets the threshold comparison run on both sides of small thresholds and lets the invert condition hold on empty cycles.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;
  localparam int SEL_W   = 64;
  localparam int CODE_W  = 12;
  localparam int UMASK_W = 8;
  localparam int THR_W   = 8;

  // select word field positions
  localparam int CODE_LO_LSB = 0;
  localparam int CODE_HI_LSB = 32;
  localparam int UMASK_LSB   = 8;
  localparam int USR_BIT     = 16;
  localparam int OS_BIT      = 17;
  localparam int EDGE_BIT    = 18;
  localparam int INT_BIT     = 20;
  localparam int EN_BIT      = 22;
  localparam int INV_BIT     = 23;
  localparam int THR_LSB     = 24;
  localparam int GO_BIT      = 40;
  localparam int HO_BIT      = 41;

  typedef struct packed {
    logic [CODE_W-1:0]  code;
    logic [UMASK_W-1:0] umask;
    logic               usr;
    logic               os;
    logic               edge_det;
    logic               int_en;
    logic               en;
    logic               inv;
    logic [THR_W-1:0]   thr;
    logic               guest_only;
    logic               host_only;
  } sel_fields_t;

  function automatic sel_fields_t decode_sel(input logic [SEL_W-1:0] s);
    sel_fields_t f;
    f.code       = {s[CODE_HI_LSB +: 4], s[CODE_LO_LSB +: 8]};
    f.umask      = s[UMASK_LSB +: UMASK_W];
    f.usr        = s[USR_BIT];
    f.os         = s[OS_BIT];
    f.edge_det   = s[EDGE_BIT];
    f.int_en     = s[INT_BIT];
    f.en         = s[EN_BIT];
    f.inv        = s[INV_BIT];
    f.thr        = s[THR_LSB +: THR_W];
    f.guest_only = s[GO_BIT];
    f.host_only  = s[HO_BIT];
    return f;
  endfunction
endpackage

// File: rtl/pmc_event_filter.sv
`timescale 1ns/1ps
module pmc_event_filter
  import pmc_pkg::*;
#(
  parameter int OCC_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  sel_fields_t        fld,
  input  logic               evt_valid,
  input  logic [CODE_W-1:0]  evt_code,
  input  logic [UMASK_W-1:0] evt_umask,
  input  logic [OCC_W-1:0]   evt_occ,
  output logic [OCC_W-1:0]   step
);
  localparam int CMP_W = (OCC_W > THR_W) ? OCC_W : THR_W;

  logic             matched;
  logic [OCC_W-1:0] occ_m;
  logic [CMP_W-1:0] occ_x;
  logic [CMP_W-1:0] thr_x;
  logic             thr_on;
  logic             at_or_above;
  logic             cond;
  logic             prev_q;

  // report qualification: code and unit-mask overlap
  assign matched = evt_valid && (evt_code == fld.code) && (|(evt_umask & fld.umask));
  assign occ_m   = matched ? evt_occ : '0;

  assign occ_x       = CMP_W'(occ_m);
  assign thr_x       = CMP_W'(fld.thr);
  assign thr_on      = |fld.thr;
  assign at_or_above = (occ_x >= thr_x);
  assign cond        = thr_on && (fld.inv ? !at_or_above : at_or_above);

  // previous-cycle condition for the edge qualifier
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cond;
  end

  always_comb begin
    if (!thr_on)           step = occ_m;
    else if (fld.edge_det) step = OCC_W'(cond && !prev_q);
    else                   step = OCC_W'(cond);
  end
endmodule

// File: rtl/pmc_mode_gate.sv
`timescale 1ns/1ps
module pmc_mode_gate
  import pmc_pkg::*;
(
  input  sel_fields_t fld,
  input  logic        priv_user,
  input  logic        guest_mode,
  input  logic        virt_mask,
  output logic        allow
);
  logic ho_eff;
  logic hg_ok;
  logic priv_ok;

  assign ho_eff = fld.host_only && !virt_mask;

  always_comb begin
    if (ho_eff == fld.guest_only) hg_ok = 1'b1;     // neither or both: any mode
    else if (ho_eff)              hg_ok = !guest_mode;
    else                          hg_ok = guest_mode;
  end

  assign priv_ok = priv_user ? fld.usr : fld.os;
  assign allow   = fld.en && priv_ok && hg_ok;
endmodule

// File: rtl/pmc_count_reg.sv
`timescale 1ns/1ps
module pmc_count_reg #(
  parameter int CNT_W  = 48,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              step_en,
  input  logic [STEP_W-1:0] step,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              wrap
);
  localparam int MSB = CNT_W - 1;

  logic [CNT_W-1:0] addend;
  logic [CNT_W-1:0] sum;

  assign addend = step_en ? CNT_W'(step) : '0;
  assign sum    = cnt_q + addend;
  assign wrap   = !wr_en && cnt_q[MSB] && !sum[MSB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (wr_en) cnt_q <= wr_data;
    else            cnt_q <= sum;
  end
endmodule

// File: rtl/pmc_event_counter.sv
`timescale 1ns/1ps
module pmc_event_counter
  import pmc_pkg::*;
#(
  parameter int CNT_W = 48,
  parameter int OCC_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_wr_en,
  input  logic [SEL_W-1:0]   sel_wr_data,
  input  logic               cnt_wr_en,
  input  logic [SEL_W-1:0]   cnt_wr_data,
  output logic [CNT_W-1:0]   cnt_value,
  input  logic               evt_valid,
  input  logic [CODE_W-1:0]  evt_code,
  input  logic [UMASK_W-1:0] evt_umask,
  input  logic [OCC_W-1:0]   evt_occ,
  input  logic               priv_user,
  input  logic               guest_mode,
  input  logic               virt_mask,
  output logic               irq,
  input  logic               irq_clr
);
  logic [SEL_W-1:0] sel_q;
  sel_fields_t      fld;
  logic [OCC_W-1:0] step;
  logic             allow;
  logic             wrap;
  logic             irq_q;
  logic             unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sel_q <= '0;
    else if (sel_wr_en) sel_q <= sel_wr_data;
  end

  assign fld = decode_sel(sel_q);

  pmc_event_filter #(.OCC_W(OCC_W)) u_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .fld       (fld),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .evt_umask (evt_umask),
    .evt_occ   (evt_occ),
    .step      (step)
  );

  pmc_mode_gate u_gate (
    .fld        (fld),
    .priv_user  (priv_user),
    .guest_mode (guest_mode),
    .virt_mask  (virt_mask),
    .allow      (allow)
  );

  pmc_count_reg #(.CNT_W(CNT_W), .STEP_W(OCC_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cnt_wr_en),
    .wr_data (cnt_wr_data[CNT_W-1:0]),
    .step_en (allow),
    .step    (step),
    .cnt_q   (cnt_value),
    .wrap    (wrap)
  );

  // sticky overflow flag; a wrap beats a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  irq_q <= 1'b0;
    else if (wrap && fld.int_en) irq_q <= 1'b1;
    else if (irq_clr)            irq_q <= 1'b0;
  end
  assign irq = irq_q;

  assign unused_bits = ^{cnt_wr_data[SEL_W-1:CNT_W], sel_q[63:42], sel_q[39:36],
                         sel_q[21], sel_q[19]};
endmodule

// File: rtl/pmc_event_counter_chk.sv
`timescale 1ns/1ps
module pmc_event_counter_chk
  import pmc_pkg::*;
#(
  parameter int CNT_W = 48,
  parameter int OCC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_wr_en,
  input logic [SEL_W-1:0] cnt_wr_data,
  input logic [CNT_W-1:0] cnt_value,
  input logic             irq,
  input logic             irq_clr,
  input logic [SEL_W-1:0] sel_q
);
  localparam int MSB = CNT_W - 1;
  localparam logic [CNT_W-1:0] STEP_MAX = CNT_W'((1 << OCC_W) - 1);

  assert_step_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr_en |=> ((cnt_value - $past(cnt_value)) <= STEP_MAX));

  assert_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_q[EN_BIT] && !cnt_wr_en) |=> $stable(cnt_value));

  assert_no_priv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_q[USR_BIT] && !sel_q[OS_BIT] && !cnt_wr_en) |=> $stable(cnt_value));

  assert_thr_unit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_q[THR_LSB +: THR_W] != '0) && !cnt_wr_en)
      |=> ((cnt_value - $past(cnt_value)) <= CNT_W'(1)));

  assert_write_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> (cnt_value == $past(cnt_wr_data[CNT_W-1:0])));

  assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(cnt_value[MSB]) && !cnt_value[MSB] && $past(sel_q[INT_BIT])));

  assert_irq_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
endmodule

bind pmc_event_counter pmc_event_counter_chk #(.CNT_W(CNT_W), .OCC_W(OCC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cnt_wr_en   (cnt_wr_en),
  .cnt_wr_data (cnt_wr_data),
  .cnt_value   (cnt_value),
  .irq         (irq),
  .irq_clr     (irq_clr),
  .sel_q       (sel_q)
);

// File: tb/pmc_event_counter_test.sv
`timescale 1ns/1ps
module pmc_event_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_wr_en = 1'b0;
  logic [63:0] sel_wr_data = '0;
  logic        cnt_wr_en = 1'b0;
  logic [63:0] cnt_wr_data = '0;
  logic [47:0] cnt_value;
  logic        evt_valid = 1'b0;
  logic [11:0] evt_code = '0;
  logic [7:0]  evt_umask = '0;
  logic [3:0]  evt_occ = '0;
  logic        priv_user = 1'b1;
  logic        guest_mode = 1'b0;
  logic        virt_mask = 1'b0;
  logic        irq;
  logic        irq_clr = 1'b0;

  always #2 clk = ~clk;

  pmc_event_counter uut (
    .clk(clk), .rst_n(rst_n), .sel_wr_en(sel_wr_en), .sel_wr_data(sel_wr_data),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data), .cnt_value(cnt_value),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_umask(evt_umask), .evt_occ(evt_occ),
    .priv_user(priv_user), .guest_mode(guest_mode), .virt_mask(virt_mask),
    .irq(irq), .irq_clr(irq_clr)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  localparam logic [63:0] S_BASE = 64'h0000_0000_0043_01C0; // code 0x0C0, umask 01, usr, os, en
  localparam logic [63:0] B_HO   = 64'h0000_0200_0000_0000;
  localparam logic [63:0] B_GO   = 64'h0000_0100_0000_0000;
  localparam logic [63:0] B_INT  = 64'h0000_0000_0010_0000;
  localparam logic [63:0] B_INV  = 64'h0000_0000_0080_0000;
  localparam logic [63:0] B_EDGE = 64'h0000_0000_0004_0000;
  localparam logic [63:0] THR2   = 64'h0000_0000_0200_0000;
  localparam logic [47:0] ONES   = 48'hFFFF_FFFF_FFFF;

  // behavioural reference model
  logic [63:0] m_sel;
  logic [47:0] m_cnt, m_nxt;
  bit          m_irq, m_prev, m_cond, m_ho, m_go, m_hg, m_ok, m_wrap;
  int          m_thr, m_occ, m_amt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = '0; m_cnt = '0; m_irq = 0; m_prev = 0;
    end else begin
      m_thr = int'(m_sel[31:24]);
      m_occ = (evt_valid && evt_code == {m_sel[35:32], m_sel[7:0]} &&
               (evt_umask & m_sel[15:8]) != 0) ? int'(evt_occ) : 0;
      if (m_thr == 0) begin
        m_cond = 0; m_amt = m_occ;
      end else begin
        m_cond = m_sel[23] ? (m_occ < m_thr) : (m_occ >= m_thr);
        m_amt  = m_sel[18] ? int'(m_cond && !m_prev) : int'(m_cond);
      end
      m_prev = m_cond;
      m_ho = m_sel[41] && !virt_mask;
      m_go = m_sel[40];
      m_hg = (m_ho == m_go) || (m_ho && !guest_mode) || (m_go && guest_mode);
      m_ok = m_sel[22] && (priv_user ? m_sel[16] : m_sel[17]) && m_hg;
      if (!m_ok) m_amt = 0;
      m_nxt  = m_cnt + 48'(m_amt);
      m_wrap = 0;
      if (cnt_wr_en) m_cnt = cnt_wr_data[47:0];
      else begin
        m_wrap = m_cnt[47] && !m_nxt[47];
        m_cnt  = m_nxt;
      end
      if (m_wrap && m_sel[20]) m_irq = 1;
      else if (irq_clr)        m_irq = 0;
      if (sel_wr_en) m_sel = sel_wr_data;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cnt_value == m_cnt, {cur_req, " count vs model"}, 64'(cnt_value), 64'(m_cnt));
      chk(irq == m_irq, {cur_req, " irq vs model"}, 64'(irq), 64'(m_irq));
    end
  end

  task automatic cyc(input bit wr, input logic [63:0] wd, input bit v, input logic [11:0] c,
                     input logic [7:0] um, input logic [3:0] oc, input bit clr);
    cnt_wr_en = wr; cnt_wr_data = wd; evt_valid = v; evt_code = c;
    evt_umask = um; evt_occ = oc; irq_clr = clr;
    @(negedge clk);
    cnt_wr_en = 0; evt_valid = 0; evt_occ = '0; irq_clr = 0;
  endtask

  task automatic ev(input logic [11:0] c, input logic [7:0] um, input logic [3:0] oc);
    cyc(0, '0, 1, c, um, oc, 0);
  endtask

  task automatic idle();
    cyc(0, '0, 0, '0, '0, '0, 0);
  endtask

  task automatic wrcnt(input logic [63:0] d);
    cyc(1, d, 0, '0, '0, '0, 0);
  endtask

  task automatic setsel(input logic [63:0] d);
    sel_wr_en = 1; sel_wr_data = d;
    @(negedge clk);
    sel_wr_en = 0;
  endtask

  task automatic expect_cnt(input logic [47:0] e, input string req);
    chk(cnt_value == e, req, 64'(cnt_value), 64'(e));
  endtask

  task automatic expect_irq(input bit e, input string req);
    chk(irq == e, req, 64'(irq), 64'(e));
  endtask

  initial begin
    #(4 * 50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    expect_cnt(48'd0, "R1 reset count");
    expect_irq(0, "R1 reset irq");
    ev(12'h0C0, 8'h01, 4'd5);
    expect_cnt(48'd0, "R1 zero select counts nothing");

    cur_req = "R2";
    setsel(S_BASE); wrcnt(0);
    ev(12'h0C0, 8'h01, 4'd3); expect_cnt(48'd3, "R2 add occurrences");
    ev(12'h0C0, 8'h03, 4'd5); expect_cnt(48'd8, "R2 second add");
    ev(12'h1C0, 8'h01, 4'd4); expect_cnt(48'd8, "R2 high nibble mismatch");
    ev(12'h0C1, 8'h01, 4'd4); expect_cnt(48'd8, "R2 low byte mismatch");
    setsel(S_BASE | 64'h0000_0001_0000_0000); wrcnt(0);
    ev(12'h1C0, 8'h01, 4'd2); expect_cnt(48'd2, "R2 high nibble match");
    ev(12'h0C0, 8'h01, 4'd2); expect_cnt(48'd2, "R2 old code no longer matches");
    cyc(0, '0, 0, 12'h1C0, 8'h01, 4'd7, 0); expect_cnt(48'd2, "R2 valid low ignored");

    cur_req = "R3";
    ev(12'h1C0, 8'h02, 4'd4); expect_cnt(48'd2, "R3 no unit-mask overlap");
    setsel(64'h0000_0001_0043_00C0); wrcnt(0);
    ev(12'h1C0, 8'hFF, 4'd4); expect_cnt(48'd0, "R3 zero select unit mask");

    cur_req = "R4";
    setsel(64'h0000_0000_0041_01C0); wrcnt(0);
    priv_user = 0; ev(12'h0C0, 8'h01, 4'd3); expect_cnt(48'd0, "R4 user-only in OS mode");
    priv_user = 1; ev(12'h0C0, 8'h01, 4'd3); expect_cnt(48'd3, "R4 user-only in user mode");
    setsel(64'h0000_0000_0042_01C0); wrcnt(0);
    ev(12'h0C0, 8'h01, 4'd3); expect_cnt(48'd0, "R4 OS-only in user mode");
    priv_user = 0; ev(12'h0C0, 8'h01, 4'd3); expect_cnt(48'd3, "R4 OS-only in OS mode");
    setsel(64'h0000_0000_0040_01C0); wrcnt(0);
    ev(12'h0C0, 8'h01, 4'd3); priv_user = 1; ev(12'h0C0, 8'h01, 4'd3);
    expect_cnt(48'd0, "R4 both privilege bits clear");
    setsel(64'h0000_0000_0003_01C0); wrcnt(0);
    ev(12'h0C0, 8'h01, 4'd3); expect_cnt(48'd0, "R4 enable clear");

    cur_req = "R5";
    setsel(S_BASE | B_HO); wrcnt(0);
    guest_mode = 0; ev(12'h0C0, 8'h01, 4'd2); expect_cnt(48'd2, "R5 host-only in host");
    guest_mode = 1; ev(12'h0C0, 8'h01, 4'd2); expect_cnt(48'd2, "R5 host-only in guest");
    setsel(S_BASE | B_GO); wrcnt(0);
    guest_mode = 0; ev(12'h0C0, 8'h01, 4'd2); expect_cnt(48'd0, "R5 guest-only in host");
    guest_mode = 1; ev(12'h0C0, 8'h01, 4'd2); expect_cnt(48'd2, "R5 guest-only in guest");

    cur_req = "R6";
    setsel(S_BASE | B_HO | B_GO); wrcnt(0);
    guest_mode = 0; ev(12'h0C0, 8'h01, 4'd2); expect_cnt(48'd2, "R6 both bits in host");
    guest_mode = 1; ev(12'h0C0, 8'h01, 4'd2); expect_cnt(48'd4, "R6 both bits in guest");
    setsel(S_BASE); wrcnt(0);
    ev(12'h0C0, 8'h01, 4'd2); expect_cnt(48'd2, "R6 neither bit in guest");

    cur_req = "R7";
    virt_mask = 1;
    setsel(S_BASE | B_HO); wrcnt(0);
    ev(12'h0C0, 8'h01, 4'd2); expect_cnt(48'd2, "R7 masked host-only counts in guest");
    setsel(S_BASE | B_GO); wrcnt(0);
    guest_mode = 0; ev(12'h0C0, 8'h01, 4'd2); expect_cnt(48'd0, "R7 guest-only in host");
    virt_mask = 0;

    cur_req = "R8";
    setsel(S_BASE | THR2); wrcnt(0);
    ev(12'h0C0, 8'h01, 4'd3); expect_cnt(48'd1, "R8 above threshold");
    ev(12'h0C0, 8'h01, 4'd2); expect_cnt(48'd2, "R8 at threshold");
    ev(12'h0C0, 8'h01, 4'd1); expect_cnt(48'd2, "R8 below threshold");
    setsel(S_BASE | THR2 | B_INV); wrcnt(0);
    ev(12'h0C0, 8'h01, 4'd1); expect_cnt(48'd1, "R8 invert below");
    ev(12'h0C0, 8'h01, 4'd3); expect_cnt(48'd1, "R8 invert above");
    idle(); expect_cnt(48'd2, "R8 invert empty cycle");

    cur_req = "R9";
    setsel(S_BASE | THR2 | B_EDGE); wrcnt(0);
    ev(12'h0C0, 8'h01, 4'd3); expect_cnt(48'd1, "R9 rising condition");
    ev(12'h0C0, 8'h01, 4'd3); expect_cnt(48'd1, "R9 held condition");
    idle(); expect_cnt(48'd1, "R9 falling condition");
    ev(12'h0C0, 8'h01, 4'd2); expect_cnt(48'd2, "R9 second rise");

    cur_req = "R10";
    setsel(S_BASE);
    wrcnt(64'hABCD_1234_5678_9ABC); expect_cnt(48'h1234_5678_9ABC, "R10 truncated write");
    cyc(1, 64'h0000_0000_0000_0100, 1, 12'h0C0, 8'h01, 4'd9, 0);
    expect_cnt(48'h100, "R10 write beats increment");

    cur_req = "R11";
    setsel(S_BASE | B_INT);
    wrcnt(64'(ONES - 48'd1));
    ev(12'h0C0, 8'h01, 4'd1); expect_cnt(ONES, "R11 top of range"); expect_irq(0, "R11 no wrap yet");
    ev(12'h0C0, 8'h01, 4'd3); expect_cnt(48'd2, "R11 wrapped count"); expect_irq(1, "R11 wrap sets irq");

    cur_req = "R12";
    idle(); expect_irq(1, "R12 sticky");
    cyc(0, '0, 0, '0, '0, '0, 1); expect_irq(0, "R12 clear");
    wrcnt(64'(ONES));
    cyc(0, '0, 1, 12'h0C0, 8'h01, 4'd1, 1);
    expect_cnt(48'd0, "R12 wrap with clear count"); expect_irq(1, "R12 wrap beats clear");
    cyc(0, '0, 0, '0, '0, '0, 1); expect_irq(0, "R12 clear after race");

    cur_req = "R11";
    wrcnt(64'(ONES)); wrcnt(0); expect_irq(0, "R11 write does not raise irq");
    setsel(S_BASE); wrcnt(64'(ONES));
    ev(12'h0C0, 8'h01, 4'd1); expect_cnt(48'd0, "R11 wrap without enable");
    expect_irq(0, "R11 interrupt disabled");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule